// File: doc/BRIEF.md
# Four-Channel Byte DMA Register Front End

This block holds the programming state of four 8-bit DMA channels. Software reaches it through a byte-wide I/O port. Each channel has a 16-bit base address, a 16-bit base count and an 8-bit page register. The 16-bit registers are loaded one byte at a time, and a single byte-pointer flip-flop shared by all channels selects which byte is accessed. The port also carries a per-channel mask control, a mode control, a flip-flop clear and a terminal-count status register that clears when read.

Each channel connects to a peripheral through an acknowledge input and an enable output. When a channel is enabled, each acknowledge moves one byte. The block reports the 24-bit physical address of that byte for the same cycle, then advances the channel's current address and decrements its remaining count. Writing any base or page register arms a reload. The next acknowledged byte first reloads the current address from the base address and the count from base count plus one. When the last byte is consumed, the enable drops and the channel's status flag is set.

Top module: `dma4_regs`

## Requirements
- R1: After reset every channel is masked with a zero count and no armed reload, so en_o reads 0. The status flags and mode_o are 0, and the byte pointer selects the low byte.
- R2: Reads and writes at offsets 0x00–0x07 use one byte pointer shared by all channels. Each such access uses the byte the pointer selects (low byte when 0, high byte when 1) and then toggles the pointer.
- R3: Any write to offset 0x0C returns the byte pointer to the low byte.
- R4: A write to offset 0x0A picks a channel with data bits 1:0 and sets that channel's mask when bit 2 is 1 or clears it when bit 2 is 0. Setting the mask drops that channel's en_o in the next cycle. A masked channel ignores acknowledges: no transfer, no state change.
- R5: A write to offset 0x0B picks a channel with data bits 1:0 and stores data bits 7:6 as its mode (0 demand, 1 single, 2 block). The stored mode appears on mode_o[2c+1:2c] for channel c.
- R6: Writing a byte of a base address, a base count or a page register arms that channel's reload. An unmasked channel drives en_o high when its reload is armed or its remaining count is nonzero, even if the base count is 0.
- R7: The first acknowledge after arming transfers at the base address. The remaining count starts from base count plus one.
- R8: Each accepted acknowledge asserts mem_valid_o, drives mem_addr_o = {page, current address} in the same cycle, then adds one to the current address and subtracts one from the remaining count.
- R9: When a transfer uses the last remaining byte, the remaining count becomes 0, en_o drops, and status bit c is set for channel c.
- R10: A read of offset 0x08 returns the terminal-count flags in bits 3:0 (bit c for channel c) with bits 7:4 at zero, and clears the flags.
- R11: Page registers for channels 0, 1, 2 and 3 sit at offsets 0x87, 0x83, 0x81 and 0x82. They can be written and read back.
- R12: Reads at offsets 0x00, 0x02, 0x04 and 0x06 return the current address of channels 0 to 3. Reads at 0x01, 0x03, 0x05 and 0x07 return the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 8 | Register offset |
| io_wr_i | input | 1 | Register write strobe |
| io_rd_i | input | 1 | Register read strobe (read side effects) |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, combinational from io_addr_i |
| dack_i | input | 4 | Per-channel transfer acknowledge |
| en_o | output | 4 | Per-channel transfer enable |
| mode_o | output | 8 | Two mode bits per channel |
| mem_addr_o | output | 24 | Physical byte address of the accepted transfer |
| mem_valid_o | output | 1 | A transfer was accepted this cycle |

## Verification
An armed reload that is lost, or one that persists, shows up at the first acknowledge afterwards. mem_addr_o carries the wrong base in that same cycle, and en_o is wrong right after a count-zero program. A byte pointer out of step shows at once as swapped bytes on the next readback. A mask or count error shows as an en_o value that is wrong one cycle after the write or acknowledge. An accepted acknowledge on a masked channel is caught by mem_valid_o going high. A later readback of the untouched remaining count also exposes it.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  localparam int NCH = 4;

  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_MASK  = 8'h0A;
  localparam logic [7:0] OFF_MODE  = 8'h0B;
  localparam logic [7:0] OFF_CLRFF = 8'h0C;

  typedef enum logic [1:0] {
    XM_DEMAND = 2'd0,
    XM_SINGLE = 2'd1,
    XM_BLOCK  = 2'd2,
    XM_RSVD   = 2'd3
  } xfer_mode_e;

  // page register offsets are scattered; order is fixed by the port map
  function automatic logic [7:0] page_off(input int ch);
    case (ch)
      0:       return 8'h87;
      1:       return 8'h83;
      2:       return 8'h81;
      default: return 8'h82;
    endcase
  endfunction
endpackage

// File: rtl/dma4_ctl.sv
module dma4_ctl #(
  parameter int NCH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ptr_clr_i,
  input  logic           ptr_step_i,
  input  logic           stat_rd_i,
  input  logic [NCH-1:0] tc_i,
  output logic           hi_o,
  output logic [NCH-1:0] flags_o
);
  logic           hi_q;
  logic [NCH-1:0] flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q    <= 1'b0;
      flags_q <= '0;
    end else begin
      if (ptr_clr_i)       hi_q <= 1'b0;
      else if (ptr_step_i) hi_q <= ~hi_q;
      // a new terminal count wins over a clearing read in the same cycle
      flags_q <= (stat_rd_i ? '0 : flags_q) | tc_i;
    end
  end

  assign hi_o    = hi_q;
  assign flags_o = flags_q;

  a_r2_ptr_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_step_i && !ptr_clr_i) |=> (hi_q != $past(hi_q)));
  a_r3_ptr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_clr_i |=> !hi_q);
  a_r10_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && tc_i == '0) |=> (flags_q == '0));
  a_r9_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tc_i) |=> ((flags_q & $past(tc_i)) == $past(tc_i)));
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_base_addr_i,
  input  logic          wr_base_cnt_i,
  input  logic          wr_page_i,
  input  logic          hi_i,
  input  logic [7:0]    wdata_i,
  input  logic          mask_wr_i,
  input  logic          mask_val_i,
  input  logic          mode_wr_i,
  input  xfer_mode_e    mode_i,
  input  logic          ack_i,
  output logic          en_o,
  output logic          go_o,
  output logic          tc_o,
  output logic [AW-1:0] cur_addr_o,
  output logic [AW-1:0] cur_cnt_o,
  output logic [PW-1:0] page_o,
  output xfer_mode_e    mode_o,
  output logic [PW+AW-1:0] phys_o
);
  localparam int CW = AW + 1;

  logic [AW-1:0] base_addr_q, base_cnt_q, cur_addr_q;
  logic [CW-1:0] cur_cnt_q;
  logic [PW-1:0] page_q;
  xfer_mode_e    mode_q;
  logic          masked_q, reload_q;

  logic [AW-1:0] eff_addr;
  logic [CW-1:0] eff_cnt;
  logic          arm;

  assign arm      = wr_base_addr_i | wr_base_cnt_i | wr_page_i;
  assign eff_addr = reload_q ? base_addr_q : cur_addr_q;
  assign eff_cnt  = reload_q ? ({1'b0, base_cnt_q} + CW'(1)) : cur_cnt_q;
  assign en_o     = ~masked_q & (reload_q | (cur_cnt_q != '0));
  assign go_o     = ack_i & en_o;
  assign tc_o     = go_o & (eff_cnt == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
      page_q      <= '0;
      mode_q      <= XM_DEMAND;
      masked_q    <= 1'b1;
      reload_q    <= 1'b0;
    end else begin
      if (wr_base_addr_i) begin
        if (hi_i) base_addr_q[AW-1 -: 8] <= wdata_i;
        else      base_addr_q[7:0]       <= wdata_i;
      end
      if (wr_base_cnt_i) begin
        if (hi_i) base_cnt_q[AW-1 -: 8] <= wdata_i;
        else      base_cnt_q[7:0]       <= wdata_i;
      end
      if (wr_page_i) page_q <= wdata_i[PW-1:0];
      if (mask_wr_i) masked_q <= mask_val_i;
      if (mode_wr_i) mode_q <= mode_i;
      if (go_o) begin
        cur_addr_q <= eff_addr + AW'(1);
        cur_cnt_q  <= eff_cnt - CW'(1);
      end
      if (arm)       reload_q <= 1'b1;
      else if (go_o) reload_q <= 1'b0;
    end
  end

  assign cur_addr_o = cur_addr_q;
  assign cur_cnt_o  = cur_cnt_q[AW-1:0];
  assign page_o     = page_q;
  assign mode_o     = mode_q;
  assign phys_o     = {page_q, eff_addr};

  a_r4_masked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_q |=> ($stable(cur_addr_q) && $stable(cur_cnt_q)));
  a_r4_mask_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_wr_i && mask_val_i) |=> !en_o);
  a_r6_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> reload_q);
  a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_o && !reload_q) |=> (cur_addr_q == AW'($past(cur_addr_q) + AW'(1))));
  a_r9_tc_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |=> (cur_cnt_q == '0));
endmodule

// File: rtl/dma4_regs.sv
module dma4_regs
  import dma4_pkg::*;
#(
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [7:0]           io_addr_i,
  input  logic                 io_wr_i,
  input  logic                 io_rd_i,
  input  logic [7:0]           io_wdata_i,
  output logic [7:0]           io_rdata_o,
  input  logic [NCH-1:0]       dack_i,
  output logic [NCH-1:0]       en_o,
  output logic [2*NCH-1:0]     mode_o,
  output logic [PW+AW-1:0]     mem_addr_o,
  output logic                 mem_valid_o
);
  localparam int PHW = PW + AW;

  logic          is_ac, is_cnt, ac_wr, ac_rd, ptr_clr, stat_rd, hi;
  logic [1:0]    ch_ac;
  logic [NCH-1:0] go, tc, flags;
  logic [AW-1:0] cur_addr [NCH];
  logic [AW-1:0] cur_cnt  [NCH];
  logic [PW-1:0] page     [NCH];
  logic [PHW-1:0] phys    [NCH];

  assign is_ac   = (io_addr_i[7:3] == 5'd0);
  assign is_cnt  = io_addr_i[0];
  assign ch_ac   = io_addr_i[2:1];
  assign ac_wr   = io_wr_i & is_ac;
  assign ac_rd   = io_rd_i & is_ac;
  assign ptr_clr = io_wr_i & (io_addr_i == OFF_CLRFF);
  assign stat_rd = io_rd_i & (io_addr_i == OFF_STAT);

  dma4_ctl #(.NCH(NCH)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ptr_clr_i  (ptr_clr),
    .ptr_step_i (ac_wr | ac_rd),
    .stat_rd_i  (stat_rd),
    .tc_i       (tc),
    .hi_o       (hi),
    .flags_o    (flags)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic       sel_ch, mask_wr, mode_wr;
    xfer_mode_e mode_c;
    assign sel_ch  = (io_wdata_i[1:0] == 2'(c));
    assign mask_wr = io_wr_i & (io_addr_i == OFF_MASK) & sel_ch;
    assign mode_wr = io_wr_i & (io_addr_i == OFF_MODE) & sel_ch;

    dma4_chan #(.AW(AW), .PW(PW)) u_chan (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .wr_base_addr_i (ac_wr & (ch_ac == 2'(c)) & ~is_cnt),
      .wr_base_cnt_i  (ac_wr & (ch_ac == 2'(c)) & is_cnt),
      .wr_page_i      (io_wr_i & (io_addr_i == page_off(c))),
      .hi_i           (hi),
      .wdata_i        (io_wdata_i),
      .mask_wr_i      (mask_wr),
      .mask_val_i     (io_wdata_i[2]),
      .mode_wr_i      (mode_wr),
      .mode_i         (xfer_mode_e'(io_wdata_i[7:6])),
      .ack_i          (dack_i[c]),
      .en_o           (en_o[c]),
      .go_o           (go[c]),
      .tc_o           (tc[c]),
      .cur_addr_o     (cur_addr[c]),
      .cur_cnt_o      (cur_cnt[c]),
      .page_o         (page[c]),
      .mode_o         (mode_c),
      .phys_o         (phys[c])
    );
    assign mode_o[2*c +: 2] = mode_c;
  end

  always_comb begin
    io_rdata_o = '0;
    if (is_ac) begin
      if (is_cnt) io_rdata_o = hi ? cur_cnt[ch_ac][AW-1 -: 8]  : cur_cnt[ch_ac][7:0];
      else        io_rdata_o = hi ? cur_addr[ch_ac][AW-1 -: 8] : cur_addr[ch_ac][7:0];
    end
    if (io_addr_i == OFF_STAT) io_rdata_o = {{(8-NCH){1'b0}}, flags};
    for (int c = 0; c < NCH; c++) begin
      if (io_addr_i == page_off(c)) io_rdata_o = 8'(page[c]);
    end
  end

  // lowest acknowledged channel owns the address bus
  always_comb begin
    mem_addr_o = '0;
    for (int c = NCH - 1; c >= 0; c--) begin
      if (go[c]) mem_addr_o = phys[c];
    end
  end
  assign mem_valid_o = |go;

  a_r8_valid_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (dack_i != '0));
  a_r4_gated_by_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dack_i & en_o) == '0) |-> !mem_valid_o);
endmodule

// File: tb/dma4_regs_tb.sv
module dma4_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 5;
  // {ack[3:0], exp_valid, exp_addr[23:0], exp_en_after[3:0]}
  localparam logic [32:0] VEC [NV] = '{
    {4'b0010, 1'b1, 24'h5A1234, 4'b0010},
    {4'b0010, 1'b1, 24'h5A1235, 4'b0010},
    {4'b0100, 1'b0, 24'h000000, 4'b0010},
    {4'b0010, 1'b1, 24'h5A1236, 4'b0000},
    {4'b0010, 1'b0, 24'h000000, 4'b0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [3:0]  dack = '0;
  logic [3:0]  en;
  logic [7:0]  mode;
  logic [23:0] mem_addr;
  logic        mem_valid;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma4_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr),
    .io_rd_i(io_rd), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .dack_i(dack), .en_o(en), .mode_o(mode), .mem_addr_o(mem_addr),
    .mem_valid_o(mem_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic ack(input logic [3:0] v, output logic vld, output logic [23:0] a);
    @(negedge clk);
    dack = v;
    #1 vld = mem_valid; a = mem_addr;
    @(posedge clk); #1;
    dack = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic        vld;
    logic [23:0] a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 en", en, 0);
    chk("R1 mode", mode, 0);
    chk("R1 valid", mem_valid, 0);
    rd(8'h08, d); chk("R1 status", d, 0);
    rd(8'h01, d); chk("R1 count lo", d, 0);
    wr(8'h0C, 8'h00);

    // program ch1: addr 0x1234, count 2, page 0x5A; unmask
    wr(8'h02, 8'h34); wr(8'h02, 8'h12);
    wr(8'h03, 8'h02); wr(8'h03, 8'h00);
    wr(8'h83, 8'h5A);
    chk("R4 masked en", en, 0);
    wr(8'h0A, 8'h01);
    chk("R6 armed en", en, 4'b0010);

    // R7 R8 R9 R4 table walk
    for (int i = 0; i < NV; i++) begin
      ack(VEC[i][32:29], vld, a);
      chk("R8 valid", vld, VEC[i][28]);
      chk("R7 R8 addr", a, VEC[i][27:4]);
      chk("R9 en after", en, VEC[i][3:0]);
    end

    // R9 R10 status flag and clear on read
    rd(8'h08, d); chk("R10 status", d, 8'h02);
    rd(8'h08, d); chk("R10 cleared", d, 8'h00);

    // R12 readback of current address and count
    wr(8'h0C, 8'h00);
    rd(8'h02, d); chk("R12 addr lo", d, 8'h37);
    rd(8'h02, d); chk("R12 addr hi", d, 8'h12);
    rd(8'h03, d); chk("R9 count lo", d, 8'h00);
    rd(8'h03, d); chk("R9 count hi", d, 8'h00);

    // R11 page registers
    rd(8'h83, d); chk("R11 page ch1", d, 8'h5A);
    wr(8'h81, 8'h77);
    rd(8'h81, d); chk("R11 page ch2", d, 8'h77);
    rd(8'h87, d); chk("R11 page ch0", d, 8'h00);

    // R5 mode register
    wr(8'h0B, 8'h83);
    chk("R5 mode block ch3", mode, 8'h80);
    wr(8'h0B, 8'h45);
    chk("R5 mode single ch1", mode, 8'h84);

    // R3 flip-flop clear mid-pair, R6 count-zero arm, R7 reload
    wr(8'h0C, 8'h00);
    wr(8'h00, 8'h11);
    wr(8'h0C, 8'h00);
    wr(8'h00, 8'h22); wr(8'h00, 8'h33);
    wr(8'h01, 8'h00); wr(8'h01, 8'h00);
    chk("R4 ch0 masked", en[0], 0);
    wr(8'h0A, 8'h00);
    chk("R6 count zero armed", en, 4'b0001);
    ack(4'b0001, vld, a);
    chk("R3 R7 addr", a, 24'h003322);
    chk("R9 single byte en", en, 4'b0000);
    rd(8'h08, d); chk("R9 status ch0", d, 8'h01);

    // R2 pointer shared across channels and stepped by reads
    rd(8'h00, d); chk("R2 ch0 lo", d, 8'h23);
    rd(8'h02, d); chk("R2 ch1 hi", d, 8'h12);

    // R4 mask set drops enable and blocks acknowledges
    wr(8'h0C, 8'h00);
    wr(8'h07, 8'h05); wr(8'h07, 8'h00);
    wr(8'h0A, 8'h03);
    chk("R4 ch3 enabled", en, 4'b1000);
    wr(8'h0A, 8'h07);
    chk("R4 mask drops en", en, 4'b0000);
    ack(4'b1000, vld, a);
    chk("R4 masked ack", vld, 0);
    wr(8'h0A, 8'h03);
    chk("R4 reload kept", en, 4'b1000);
    ack(4'b1000, vld, a);
    chk("R7 ch3 valid", vld, 1);
    chk("R7 ch3 addr", a, 24'h000000);
    rd(8'h07, d); chk("R7 ch3 count", d, 8'h05);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule